// File: doc/BRIEF.md
# ADC Sequencer Stop-Mode Controller

This block decides what an analog-to-digital conversion sequence does when the chip enters or leaves its low-power stop mode. A single policy bit picks one of two behaviours, and it is sampled at the moment stop is entered. With the bit clear, a sequence that is running gets a one-cycle abort strobe. The sequence sleeps through stop and gets a one-cycle restart strobe when stop ends. With the bit set, the sequence keeps converting. The clock-select output moves the conversion clock to the internal oscillator, whose rate does not depend on the bus prescaler.

Any conversion in flight across a mode transition is marked as straddling. While that mark is held, the conversion core must not write a result, set a completion flag or run a compare for that conversion. The mark clears at the next conversion boundary. The external trigger is passed through only in normal run operation.

On leaving a stop period in which conversions ran on the internal clock, a down-counter loaded from a configurable length holds a busy flag high. While the flag is high, registers must not be accessed. The clock goes back to the bus-derived source only after that window has expired, and then only when no conversion would be cut in half.

Top module: `adc_stop_ctrl`

## Requirements
- R1: After reset, all of `clkSelInt`, `seqAbort`, `seqRestart`, `convSuppress` and `regBusy` are 0, and `extTrigOut` follows `extTrigIn`.
- R2: The policy bit is clear (0). Stop is entered while `seqActive` is 1. `seqAbort` is then 1 for exactly the one cycle after the entry edge, and `clkSelInt` stays 0. If `seqActive` is 0 at entry, no abort is given.
- R3: Under the clear policy, when `stopReq` falls, `seqRestart` is 1 for exactly the one cycle after that edge, but only if an abort was given at entry.
- R4: The policy bit is set (1). `clkSelInt` becomes 1 in the cycle after the stop entry edge, and no abort is given.
- R5: Under the set policy, each stop entry or exit edge taken with `seqActive` 1 sets `convSuppress`. It stays 1 up to and including the cycle in which `convBoundary` is 1, and is 0 after that edge. Transitions under the clear policy never set it.
- R6: `extTrigOut` equals `extTrigIn` in run operation and is 0 from the stop entry edge until the block is back in run operation.
- R7: After a stop exit under the set policy, `regBusy` is 1 for exactly `recoveryLen` cycles, beginning in the cycle after the exit edge. A length of 0 gives no busy cycles.
- R8: After the recovery count reaches zero, `clkSelInt` stays 1 until an edge at which `seqActive` is 0 or `convBoundary` is 1. It becomes 0 after that edge.
- R9: Changes of the policy bit while in stop do not affect the behaviour chosen at entry.
- R10: If `stopReq` rises again during the recovery window, `regBusy` goes to 0 after that edge, and `clkSelInt` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| stopReq | input | 1 | Stop mode requested by the system |
| stopClkEn | input | 1 | Policy: 1 continues converting on the internal clock, 0 aborts and restarts |
| seqActive | input | 1 | A conversion sequence is in progress |
| convBoundary | input | 1 | One-cycle pulse at the end of each single conversion |
| extTrigIn | input | 1 | External trigger from the trigger logic |
| recoveryLen | input | CNT_W | Recovery window length in cycles |
| clkSelInt | output | 1 | Conversion clock select: 1 internal, 0 prescaled bus |
| seqAbort | output | 1 | One-cycle abort strobe to the sequencer |
| seqRestart | output | 1 | One-cycle restart strobe to the sequencer |
| convSuppress | output | 1 | Current conversion straddles a transition; drop result, flag and compare |
| extTrigOut | output | 1 | Gated external trigger |
| regBusy | output | 1 | Register access forbidden during recovery |

## Verification
The assertions assume three things about the inputs. `convBoundary` is pulsed only while `seqActive` is 1. `recoveryLen` is held steady from a stop exit until the recovery window ends. `stopReq` is a level that stays put for at least one cycle per change. The bench drives all inputs on the falling clock edge and sets `recoveryLen` before each exit. It raises `convBoundary` only during an active sequence, and never on the same edge as a stop transition. That keeps the stimulus away from the otherwise unspecified case of a boundary coinciding with a transition.

// File: rtl/adc_stop_pkg.sv
package adc_stop_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HALT  = 2'd1,
    ST_SCONV = 2'd2,
    ST_REC   = 2'd3
  } stopState_t;

  typedef struct packed {
    logic loadCnt;
    logic clrCnt;
    logic setTaint;
    logic abortPulse;
    logic restartPulse;
  } stopStrobe_t;

endpackage

// File: rtl/adc_stop_fsm.sv
module adc_stop_fsm
  import adc_stop_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        stopReq,
  input  logic        stopClkEn,
  input  logic        seqActive,
  input  logic        convBoundary,
  input  logic        cntZero,
  output stopStrobe_t stb,
  output logic        clkSelInt,
  output logic        inRun
);

  stopState_t state, stateNxt;
  logic pendRestart, pendRestartNxt;

  always_comb begin
    stateNxt       = state;
    pendRestartNxt = pendRestart;
    stb            = '0;
    unique case (state)
      ST_RUN: if (stopReq) begin
        if (stopClkEn) begin
          stateNxt     = ST_SCONV;
          stb.setTaint = seqActive;
        end else begin
          stateNxt       = ST_HALT;
          stb.abortPulse = seqActive;
          pendRestartNxt = seqActive;
        end
      end
      ST_HALT: if (!stopReq) begin
        stateNxt         = ST_RUN;
        stb.restartPulse = pendRestart;
        pendRestartNxt   = 1'b0;
      end
      ST_SCONV: if (!stopReq) begin
        stateNxt     = ST_REC;
        stb.loadCnt  = 1'b1;
        stb.setTaint = seqActive;
      end
      ST_REC: begin
        if (stopReq) begin
          stateNxt     = ST_SCONV;
          stb.clrCnt   = 1'b1;
          stb.setTaint = seqActive;
        end else if (cntZero && (!seqActive || convBoundary)) begin
          stateNxt = ST_RUN;
        end
      end
      default: stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_RUN;
      pendRestart <= 1'b0;
    end else begin
      state       <= stateNxt;
      pendRestart <= pendRestartNxt;
    end
  end

  assign clkSelInt = (state == ST_SCONV) || (state == ST_REC);
  assign inRun     = (state == ST_RUN);

  AST_CLK_RISE_ON_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkSelInt) |-> $past(stopReq) && $past(stopClkEn)); // R4
  AST_CLK_FALL_SAFE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkSelInt) |-> $past(!seqActive || convBoundary)); // R8
  AST_HALT_KEEPS_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HALT) |-> !clkSelInt); // R2

endmodule

// File: rtl/adc_stop_dp.sv
module adc_stop_dp
  import adc_stop_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  stopStrobe_t      stb,
  input  logic             convBoundary,
  input  logic [CNT_W-1:0] recoveryLen,
  output logic             cntZero,
  output logic             regBusy,
  output logic             convSuppress,
  output logic             seqAbort,
  output logic             seqRestart
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             taint;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt        <= '0;
      taint      <= 1'b0;
      seqAbort   <= 1'b0;
      seqRestart <= 1'b0;
    end else begin
      if (stb.clrCnt)       cnt <= '0;
      else if (stb.loadCnt) cnt <= recoveryLen;
      else if (cnt != '0)   cnt <= cnt - CNT_ONE;

      if (stb.setTaint)     taint <= 1'b1;
      else if (convBoundary) taint <= 1'b0;

      seqAbort   <= stb.abortPulse;
      seqRestart <= stb.restartPulse;
    end
  end

  assign cntZero      = (cnt == '0);
  assign regBusy      = !cntZero;
  assign convSuppress = taint;

  AST_CNT_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (regBusy && !stb.loadCnt && !stb.clrCnt) |=> (cnt == $past(cnt) - CNT_ONE)); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({seqAbort, seqRestart})); // R3
  AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    seqAbort |=> !seqAbort); // R2

endmodule

// File: rtl/adc_stop_ctrl.sv
module adc_stop_ctrl
  import adc_stop_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stopReq,
  input  logic             stopClkEn,
  input  logic             seqActive,
  input  logic             convBoundary,
  input  logic             extTrigIn,
  input  logic [CNT_W-1:0] recoveryLen,
  output logic             clkSelInt,
  output logic             seqAbort,
  output logic             seqRestart,
  output logic             convSuppress,
  output logic             extTrigOut,
  output logic             regBusy
);

  stopStrobe_t stb;
  logic        cntZero;
  logic        inRun;

  adc_stop_fsm u_fsm (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .stopClkEn(stopClkEn),
    .seqActive(seqActive), .convBoundary(convBoundary), .cntZero(cntZero),
    .stb(stb), .clkSelInt(clkSelInt), .inRun(inRun)
  );

  adc_stop_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .convBoundary(convBoundary),
    .recoveryLen(recoveryLen), .cntZero(cntZero), .regBusy(regBusy),
    .convSuppress(convSuppress), .seqAbort(seqAbort), .seqRestart(seqRestart)
  );

  assign extTrigOut = extTrigIn && inRun;

  AST_TRIG_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    clkSelInt |-> !extTrigOut); // R6
  AST_BUSY_ON_INT: assert property (@(posedge clk) disable iff (!rstN)
    regBusy |-> clkSelInt); // R7
  AST_ABORT_ON_BUS: assert property (@(posedge clk) disable iff (!rstN)
    seqAbort |-> !clkSelInt); // R2

endmodule

// File: tb/adc_stop_ctrl_tb.sv
module adc_stop_ctrl_tb;

  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rstN, stopReq, stopClkEn, seqActive, convBoundary, extTrigIn;
  logic [CNT_W-1:0] recoveryLen;
  logic clkSelInt, seqAbort, seqRestart, convSuppress, extTrigOut, regBusy;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  adc_stop_ctrl #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .stopClkEn(stopClkEn),
    .seqActive(seqActive), .convBoundary(convBoundary), .extTrigIn(extTrigIn),
    .recoveryLen(recoveryLen), .clkSelInt(clkSelInt), .seqAbort(seqAbort),
    .seqRestart(seqRestart), .convSuppress(convSuppress),
    .extTrigOut(extTrigOut), .regBusy(regBusy)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rstN = 1'b0; stopReq = 0; stopClkEn = 0; seqActive = 0;
    convBoundary = 0; extTrigIn = 1; recoveryLen = '0;
    tick(); tick();
    rstN = 1'b1;
    tick();
    chk("R1", "clkSelInt", clkSelInt, 1'b0);
    chk("R1", "seqAbort", seqAbort, 1'b0);
    chk("R1", "seqRestart", seqRestart, 1'b0);
    chk("R1", "convSuppress", convSuppress, 1'b0);
    chk("R1", "regBusy", regBusy, 1'b0);
    chk("R1", "extTrigOut", extTrigOut, 1'b1);
  endtask

  task automatic t_abort_restart();
    stopClkEn = 0; seqActive = 1; stopReq = 1;
    tick();
    chk("R2", "abort strobe", seqAbort, 1'b1);
    chk("R2", "clock stays bus", clkSelInt, 1'b0);
    chk("R5", "no suppress policy0", convSuppress, 1'b0);
    chk("R6", "trigger blocked in halt", extTrigOut, 1'b0);
    tick();
    chk("R2", "abort one cycle", seqAbort, 1'b0);
    stopClkEn = 1;
    tick();
    chk("R9", "policy change ignored", clkSelInt, 1'b0);
    stopReq = 0;
    tick();
    chk("R3", "restart strobe", seqRestart, 1'b1);
    chk("R6", "trigger back in run", extTrigOut, 1'b1);
    chk("R5", "no suppress on exit policy0", convSuppress, 1'b0);
    tick();
    chk("R3", "restart one cycle", seqRestart, 1'b0);
  endtask

  task automatic t_idle_policy0();
    stopClkEn = 0; seqActive = 0; stopReq = 1;
    tick();
    chk("R2", "no abort when idle", seqAbort, 1'b0);
    stopReq = 0;
    tick();
    chk("R3", "no restart without abort", seqRestart, 1'b0);
  endtask

  task automatic t_continue();
    stopClkEn = 1; seqActive = 1; stopReq = 1;
    tick();
    chk("R4", "internal clock", clkSelInt, 1'b1);
    chk("R4", "no abort", seqAbort, 1'b0);
    chk("R5", "entry suppress", convSuppress, 1'b1);
    chk("R6", "trigger blocked", extTrigOut, 1'b0);
    stopClkEn = 0;
    tick();
    chk("R9", "policy change ignored", clkSelInt, 1'b1);
    convBoundary = 1;
    chk("R5", "suppress at boundary", convSuppress, 1'b1);
    tick();
    convBoundary = 0;
    chk("R5", "suppress cleared", convSuppress, 1'b0);
    recoveryLen = 8'd3; stopReq = 0;
    tick();
    chk("R7", "busy cycle 1", regBusy, 1'b1);
    chk("R5", "exit suppress", convSuppress, 1'b1);
    chk("R6", "trigger blocked in recovery", extTrigOut, 1'b0);
    tick();
    chk("R7", "busy cycle 2", regBusy, 1'b1);
    tick();
    chk("R7", "busy cycle 3", regBusy, 1'b1);
    tick();
    chk("R7", "busy ends", regBusy, 1'b0);
    tick();
    chk("R8", "hold internal mid conversion", clkSelInt, 1'b1);
    convBoundary = 1;
    tick();
    convBoundary = 0;
    chk("R8", "back to bus at boundary", clkSelInt, 1'b0);
    chk("R5", "suppress cleared at boundary", convSuppress, 1'b0);
    chk("R6", "trigger passes again", extTrigOut, 1'b1);
    seqActive = 0;
  endtask

  task automatic t_zero_recovery();
    stopClkEn = 1; seqActive = 0; stopReq = 1;
    tick();
    chk("R5", "no suppress when idle", convSuppress, 1'b0);
    recoveryLen = 8'd0; stopReq = 0;
    tick();
    chk("R7", "zero length no busy", regBusy, 1'b0);
    chk("R8", "still internal one cycle", clkSelInt, 1'b1);
    tick();
    chk("R8", "idle return to bus", clkSelInt, 1'b0);
  endtask

  task automatic t_reenter();
    stopClkEn = 1; seqActive = 0; stopReq = 1;
    tick();
    recoveryLen = 8'd5; stopReq = 0;
    tick(); tick();
    chk("R7", "busy before reentry", regBusy, 1'b1);
    stopReq = 1;
    tick();
    chk("R10", "busy dropped", regBusy, 1'b0);
    chk("R10", "clock stays internal", clkSelInt, 1'b1);
    recoveryLen = 8'd0; stopReq = 0;
    tick(); tick();
    chk("R10", "returns to bus", clkSelInt, 1'b0);
  endtask

  initial begin
    t_reset();
    t_abort_restart();
    t_idle_policy0();
    t_continue();
    t_zero_recovery();
    t_reenter();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule